// File: doc/BRIEF.md
# Wiper Position Register with Power-Up Recall

This block holds the volatile tap position of a digitally controlled resistor divider. An 8-bit position value selects exactly one of 256 taps. Tap 0 ties the wiper to the low end of the array, and tap 255 ties it to the high end. The block presents the selected tap as a one-hot vector, and it returns the position on a separate port for read-back.

Four sources can change the position:

- When reset is released, the position is restored from bank-0 data register 0.
- A direct write loads a host value.
- A parallel transfer copies any one of the four bank-0 data registers.
- Step requests move the position one tap at a time, and stepping stops at both ends of the array.

The register takes its new value one clock after the request. The one-hot tap output follows only after a fixed response delay of `RESP_DLY` clock cycles. This delay stands for the wiper settling time of a few microseconds. A one-cycle strobe marks the cycle in which the tap output takes the new position.

Top module: `wiper_pos_reg`

## Requirements
- R1: `tap_o` always has exactly one bit set. Bit i set means the wiper sits on tap i: bit 0 is the low terminal and bit 255 is the high terminal.
- R2: On the first clock edge after `rst_ni` is released, `pos_o` loads `bank_i[7:0]` (data register 0). This recall wins over every other request made in that cycle.
- R3: `wr_en_i` loads `wr_data_i` into the position at the next clock edge. It wins over a transfer and over a step made in the same cycle.
- R4: `xfer_en_i` loads data register `xfer_sel_i` (0 to 3), taken from `bank_i[8*sel +: 8]`. It wins over a step made in the same cycle.
- R5: `step_en_i` with `step_up_i`=1 adds one to the position, and with `step_up_i`=0 subtracts one.
- R6: A step up at 255 and a step down at 0 leave the position unchanged, with no wrap. Such a step still counts as a load.
- R7: `pos_o` shows the new position in the cycle after the edge that accepted the request.
- R8: Every accepted load restarts the response delay, including a load made while an earlier one is still waiting. `tap_o` takes the one-hot code of the position exactly `RESP_DLY` edges after the last load. `settle_o` is 1 in exactly that cycle. At all other times `tap_o` holds its value.
- R9: While `rst_ni` is low, `pos_o` is 0, `tap_o` has only bit 0 set and `settle_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release triggers the recall |
| bank_i | input | 32 | Bank-0 data registers 0 to 3, register n in bits [8n+7:8n] |
| wr_en_i | input | 1 | Direct write request |
| wr_data_i | input | 8 | Direct write value |
| xfer_en_i | input | 1 | Parallel transfer request |
| xfer_sel_i | input | 2 | Data register chosen for the transfer |
| step_en_i | input | 1 | Single-step request |
| step_up_i | input | 1 | Step direction: 1 toward the high end, 0 toward the low end |
| pos_o | output | 8 | Current position, for read-back |
| tap_o | output | 256 | One-hot tap select, delayed |
| settle_o | output | 1 | One-cycle strobe when `tap_o` takes a new position |

## Verification
The assertions assume that `rst_ni` is driven low from time zero. They also assume that `RESP_DLY` is at least 1, so the timer always has a nonzero count to run down. The properties about write priority and saturation assume the request inputs are stable around the sampling edge. The stimulus meets this by changing every input on the falling edge and reading every output there as well. Any combination of requests in one cycle is legal, so the bench drives several of them together on purpose to exercise the priority order.

// File: rtl/wiper_pkg.sv
`timescale 1ns/1ps
package wiper_pkg;
  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_RECALL = 3'd1,
    SRC_WRITE  = 3'd2,
    SRC_XFER   = 3'd3,
    SRC_STEP   = 3'd4
  } load_src_e;
endpackage

// File: rtl/wiper_step.sv
`timescale 1ns/1ps
module wiper_step #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] pos_i,
  input  logic         up_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] POS_MAX = {W{1'b1}};
  localparam logic [W-1:0] POS_MIN = '0;

  // saturate at both ends of the array
  always_comb begin
    if (up_i) val_o = (pos_i == POS_MAX) ? pos_i : pos_i + W'(1);
    else      val_o = (pos_i == POS_MIN) ? pos_i : pos_i - W'(1);
  end
endmodule

// File: rtl/wiper_src_arb.sv
`timescale 1ns/1ps
module wiper_src_arb
  import wiper_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned NDR  = 4,
  parameter int unsigned SELW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic [NDR*W-1:0] bank_i,
  input  logic             recall_i,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             xfer_en_i,
  input  logic [SELW-1:0]  xfer_sel_i,
  input  logic             step_en_i,
  input  logic [W-1:0]     step_val_i,
  output logic             load_o,
  output logic [W-1:0]     next_o,
  output load_src_e        src_o
);
  logic [W-1:0] xfer_val;
  assign xfer_val = bank_i[xfer_sel_i*W +: W];

  // fixed priority: recall, write, transfer, step
  always_comb begin
    src_o  = SRC_NONE;
    next_o = '0;
    if (recall_i) begin
      src_o  = SRC_RECALL;
      next_o = bank_i[W-1:0];
    end else if (wr_en_i) begin
      src_o  = SRC_WRITE;
      next_o = wr_data_i;
    end else if (xfer_en_i) begin
      src_o  = SRC_XFER;
      next_o = xfer_val;
    end else if (step_en_i) begin
      src_o  = SRC_STEP;
      next_o = step_val_i;
    end
  end

  assign load_o = (src_o != SRC_NONE);
endmodule

// File: rtl/wiper_settle_timer.sv
`timescale 1ns/1ps
module wiper_settle_timer #(
  parameter int unsigned DLY = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  // a fresh load restarts the count and suppresses the pending fire
  assign fire_o = busy_q && (cnt_q == CW'(1)) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= CW'(DLY);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CW'(1)) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assert_cnt_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0 && cnt_q <= CW'(DLY)));

  assert_fire_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/wiper_tap_decode.sv
`timescale 1ns/1ps
module wiper_tap_decode #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 1 << W
) (
  input  logic [W-1:0] pos_i,
  output logic [N-1:0] tap_o
);
  for (genvar i = 0; i < N; i++) begin : g_tap
    assign tap_o[i] = (pos_i == W'(i));
  end
endmodule

// File: rtl/wiper_pos_reg.sv
`timescale 1ns/1ps
module wiper_pos_reg
  import wiper_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned NDR      = 4,
  parameter int unsigned RESP_DLY = 1000,
  localparam int unsigned N       = 1 << W,
  localparam int unsigned SELW    = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NDR*W-1:0] bank_i,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             xfer_en_i,
  input  logic [SELW-1:0]  xfer_sel_i,
  input  logic             step_en_i,
  input  logic             step_up_i,
  output logic [W-1:0]     pos_o,
  output logic [N-1:0]     tap_o,
  output logic             settle_o
);
  localparam logic [W-1:0] POS_MAX = {W{1'b1}};

  logic [W-1:0] pos_q;
  logic         recall_q;
  logic [N-1:0] tap_q;
  logic         settle_q;

  logic [W-1:0] step_val;
  logic         load;
  logic [W-1:0] next_pos;
  load_src_e    src;
  logic [N-1:0] tap_dec;
  logic         fire;

  wiper_step #(.W(W)) u_step (
    .pos_i (pos_q),
    .up_i  (step_up_i),
    .val_o (step_val)
  );

  wiper_src_arb #(.W(W), .NDR(NDR), .SELW(SELW)) u_arb (
    .bank_i     (bank_i),
    .recall_i   (recall_q),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .xfer_en_i  (xfer_en_i),
    .xfer_sel_i (xfer_sel_i),
    .step_en_i  (step_en_i),
    .step_val_i (step_val),
    .load_o     (load),
    .next_o     (next_pos),
    .src_o      (src)
  );

  wiper_settle_timer #(.DLY(RESP_DLY)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .fire_o (fire)
  );

  wiper_tap_decode #(.W(W), .N(N)) u_dec (
    .pos_i (pos_q),
    .tap_o (tap_dec)
  );

  // recall pending from reset until the first edge after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) recall_q <= 1'b1;
    else         recall_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pos_q <= '0;
    else if (load) pos_q <= next_pos;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q    <= N'(1);
      settle_q <= 1'b0;
    end else begin
      settle_q <= fire;
      if (fire) tap_q <= tap_dec;
    end
  end

  assign pos_o    = pos_q;
  assign tap_o    = tap_q;
  assign settle_o = settle_q;

  assert_tap_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tap_o) == 1);

  assert_recall_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(recall_q) |-> pos_o == $past(bank_i[W-1:0]));

  assert_recall_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_q |-> src == SRC_RECALL);

  assert_write_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !recall_q) |=> pos_o == $past(wr_data_i));

  assert_sat_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && step_up_i && pos_o == POS_MAX && !recall_q && !wr_en_i && !xfer_en_i)
    |=> pos_o == POS_MAX);

  assert_sat_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !step_up_i && pos_o == '0 && !recall_q && !wr_en_i && !xfer_en_i)
    |=> pos_o == '0);

  assert_settle_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_o |-> tap_o[pos_o]);

  assert_tap_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !settle_o |-> $stable(tap_o));
endmodule

// File: tb/tb_wiper_pos_reg.sv
`timescale 1ns/1ps
module tb_wiper_pos_reg;
  localparam int W = 8;
  localparam int NDR = 4;
  localparam int DLY = 3;
  localparam int N = 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic [NDR*W-1:0] bank;
  logic             wr_en;
  logic [W-1:0]     wr_data;
  logic             xfer_en;
  logic [1:0]       xfer_sel;
  logic             step_en;
  logic             step_up;
  logic [W-1:0]     pos;
  logic [N-1:0]     tap;
  logic             settle;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [N-1:0] exp_tap;

  wiper_pos_reg #(.W(W), .NDR(NDR), .RESP_DLY(DLY)) dut (
    .clk_i (clk), .rst_ni (rst_n), .bank_i (bank),
    .wr_en_i (wr_en), .wr_data_i (wr_data),
    .xfer_en_i (xfer_en), .xfer_sel_i (xfer_sel),
    .step_en_i (step_en), .step_up_i (step_up),
    .pos_o (pos), .tap_o (tap), .settle_o (settle)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; xfer_en = 0; step_en = 0;
  endtask

  // apply current inputs for one edge, then clear
  task automatic edge_go();
    @(negedge clk);
    idle();
  endtask

  task automatic do_write(logic [W-1:0] d);
    wr_en = 1; wr_data = d;
    edge_go();
  endtask

  task automatic do_step(bit up);
    step_en = 1; step_up = up;
    edge_go();
  endtask

  // called at the negedge right after the last load edge
  task automatic wait_tap(string req, logic [W-1:0] p);
    for (int k = 1; k <= DLY; k++) begin
      @(negedge clk);
      if (k < DLY) begin
        chk(req, N'(settle), N'(0));
        chk(req, tap, exp_tap);
      end else begin
        exp_tap = N'(1) << p;
        chk(req, N'(settle), N'(1));
        chk(req, tap, exp_tap);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); step_up = 0; xfer_sel = 0;
    bank = {8'hC3, 8'h5A, 8'hA5, 8'h3C};
    wr_data = 8'h77; wr_en = 1; xfer_en = 1; step_en = 1;
    exp_tap = N'(1);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", N'(pos), N'(0));
    chk("R9", tap, N'(1));
    chk("R9", N'(settle), N'(0));
    rst_n = 1;
    @(negedge clk);
    // R2 recall beats concurrent write/transfer/step
    chk("R2", N'(pos), N'(8'h3C));
    idle();
    wait_tap("R8 recall", 8'h3C);

    // R3/R7 write sweep; R8 tap held while loads keep restarting
    for (int v = 0; v < N; v++) begin
      do_write(W'(v));
      chk("R3", N'(pos), N'(v));
      chk("R8 restart", tap, exp_tap);
    end
    wait_tap("R8 write", 8'hFF);

    // R4 transfer of every register
    for (int s = 0; s < NDR; s++) begin
      xfer_en = 1; xfer_sel = 2'(s);
      edge_go();
      chk("R4", N'(pos), N'(bank[s*W +: W]));
      wait_tap("R8 xfer", bank[s*W +: W]);
    end

    // R3 priority over transfer and step
    wr_en = 1; wr_data = 8'h81; xfer_en = 1; xfer_sel = 2; step_en = 1; step_up = 1;
    edge_go();
    chk("R3 priority", N'(pos), N'(8'h81));
    // R4 priority over step
    xfer_en = 1; xfer_sel = 1; step_en = 1; step_up = 0;
    edge_go();
    chk("R4 priority", N'(pos), N'(8'hA5));
    wait_tap("R8 priority", 8'hA5);

    // R5/R6 full step sweeps with saturation
    do_write(8'h00);
    wait_tap("R8", 8'h00);
    for (int v = 1; v < N; v++) begin
      do_step(1);
      chk("R5 up", N'(pos), N'(v));
    end
    do_step(1);
    chk("R6 high", N'(pos), N'(255));
    wait_tap("R6 high tap", 8'hFF);
    for (int v = N - 2; v >= 0; v--) begin
      do_step(0);
      chk("R5 down", N'(pos), N'(v));
    end
    do_step(0);
    chk("R6 low", N'(pos), N'(0));
    wait_tap("R6 low tap", 8'h00);

    // R8 load during pending delay: first value never shown
    do_write(8'h10);
    @(negedge clk);
    chk("R8 pend", tap, exp_tap);
    do_write(8'h20);
    wait_tap("R8 pend", 8'h20);

    // R2/R9 reset again, recall new register 0 value
    rst_n = 0;
    @(negedge clk);
    chk("R9 rerun", N'(pos), N'(0));
    chk("R9 rerun", tap, N'(1));
    exp_tap = N'(1);
    bank[7:0] = 8'h99;
    rst_n = 1;
    @(negedge clk);
    chk("R2 rerun", N'(pos), N'(8'h99));
    wait_tap("R8 rerun", 8'h99);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule